// File: doc/BRIEF.md
# Pulse-Distance Infrared Frame Transmitter

This block sends infrared remote-control frames in the common 32-bit pulse-distance format. It does this by switching a modulation carrier on and off. A start request in idle captures a 32-bit code and a repeat count. The block then sends a long leader burst and a leader space. After that come 32 data bits, each a fixed burst followed by a short or long space, and finally one stop burst. When the repeat count is non-zero, a short repeat frame follows for each unit of the count. Every repeat frame starts on a boundary of a fixed repeat period.

All durations are counted in ticks. A clock-enable prescaler produces one tick per `CLK_PER_TICK` clocks, which is one microsecond with the default values. The prescaler is restarted when a start request is accepted, so every segment lasts exactly its tick count times `CLK_PER_TICK` clocks.

A period countdown is loaded at the start of each frame and drops by one on every tick. The gap before a repeat frame is whatever is left of that countdown. As a result, repeat frames stay aligned to the period whatever bits the data frame carried. A free-running divider produces a carrier at roughly one third duty. The infrared output is this carrier gated by the carrier-enable signal.

Top module: `nec_ir_tx`

## Requirements
- R1: An accepted start begins a carrier burst of LEAD_MARK_T ticks on the very next cycle, followed by a carrier-off space of LEAD_SPACE_T ticks. One tick is CLK_PER_TICK clocks.
- R2: Data bits go out in the order code[0], code[1], … code[31]. With this order, the byte in code[7:0] (address) goes first, then code[15:8] (address complement), code[23:16] (command) and code[31:24] (command complement), each least significant bit first.
- R3: Each data bit is a burst of BIT_MARK_T ticks followed by a carrier-off space of ONE_SPACE_T ticks for a 1 or ZERO_SPACE_T ticks for a 0.
- R4: After the 32nd bit, a stop burst of BIT_MARK_T ticks is sent. With a repeat count of 0, the block goes idle at the end of that burst.
- R5: A repeat frame is a burst of LEAD_MARK_T ticks, then a carrier-off space of RPT_SPACE_T ticks, then a stop burst of BIT_MARK_T ticks.
- R6: Each repeat frame begins exactly RPT_PERIOD_T ticks after the start of the frame before it, with the carrier off in between.
- R7: With a repeat count of N, exactly N repeat frames are sent. The block goes idle at the end of the last repeat stop burst.
- R8: A start request while busy is ignored. Neither the code, the repeat count nor the timing of the frame in progress changes.
- R9: ir_out is low whenever carrier_en is low. While carrier_en is high, ir_out follows the carrier, which has a period of CAR_DIV clocks and is high for CAR_DIV/3 clocks per period.
- R10: During and after reset, busy, done, carrier_en and ir_out are low. A reset in the middle of a transfer returns the block to idle.
- R11: busy is high from the cycle after an accepted start until the transfer ends. done is a single-cycle pulse in the first idle cycle after a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Start request, accepted only while idle |
| code | input | 32 | Frame code, bit 0 sent first |
| rpt_num | input | 8 | Number of repeat frames after the data frame |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when a transfer ends |
| carrier_en | output | 1 | High during carrier bursts |
| ir_out | output | 1 | Modulated infrared drive |

## Verification
The bench builds the block with two clocks per tick, a 6-clock carrier and single-digit tick counts for every segment. The repeat period is 250 ticks, which leaves a gap for any data pattern. At this scale a full data frame takes about 400 clocks. That makes it affordable to walk a single one through all 32 code positions, send all-zero and all-one codes, and run transfers with several repeat frames. Each of these is compared run by run against a burst/space list computed arithmetically from the code. The small carrier divider also puts several whole carrier periods inside one leader burst, so the carrier period and duty can be measured directly at the pins.

// File: rtl/nec_tx_pkg.sv
package nec_tx_pkg;

  localparam int CODE_W = 32;

  typedef enum logic [3:0] {
    SEG_IDLE,
    SEG_LEAD_MARK,
    SEG_LEAD_SPACE,
    SEG_BIT_MARK,
    SEG_BIT_SPACE,
    SEG_STOP_MARK,
    SEG_GAP,
    SEG_RPT_MARK,
    SEG_RPT_SPACE,
    SEG_RPT_STOP
  } seg_e;

  function automatic logic is_burst(seg_e s);
    return (s == SEG_LEAD_MARK) || (s == SEG_BIT_MARK) || (s == SEG_STOP_MARK) ||
           (s == SEG_RPT_MARK)  || (s == SEG_RPT_STOP);
  endfunction

endpackage

// File: rtl/nec_rst_sync.sv
module nec_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/nec_tick_gen.sv
module nec_tick_gen #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);

  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    if (clr) begin
      cnt_d = '0;
    end else if (cnt_q == LAST) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tick = (cnt_q == LAST);

endmodule

// File: rtl/nec_carrier_gen.sv
module nec_carrier_gen #(
  parameter int PERIOD_CLK = 1316,
  parameter int HIGH_CLK   = 438
) (
  input  logic clk,
  input  logic rst_n,
  output logic carrier
);

  localparam int W = (PERIOD_CLK > 1) ? $clog2(PERIOD_CLK) : 1;
  localparam logic [W-1:0] LAST   = W'(PERIOD_CLK - 1);
  localparam logic [W-1:0] HIGH_C = W'(HIGH_CLK);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         car_q;
  logic         car_d;

  always_comb begin
    if (cnt_q == LAST) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + W'(1);
    end
    car_d = (cnt_d < HIGH_C);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      car_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      car_q <= car_d;
    end
  end

  assign carrier = car_q;

endmodule

// File: rtl/nec_frame_seq.sv
module nec_frame_seq
  import nec_tx_pkg::*;
#(
  parameter int LEAD_MARK_T  = 9000,
  parameter int LEAD_SPACE_T = 4500,
  parameter int BIT_MARK_T   = 560,
  parameter int ZERO_SPACE_T = 560,
  parameter int ONE_SPACE_T  = 1690,
  parameter int RPT_SPACE_T  = 2250,
  parameter int RPT_PERIOD_T = 108000,
  parameter int RPT_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] code,
  input  logic [RPT_W-1:0]  rpt_num,
  input  logic              tick,
  output logic              tick_clr,
  output logic              busy,
  output logic              done,
  output logic              carrier_en
);

  localparam int W    = $clog2(RPT_PERIOD_T + 1);
  localparam int BW   = $clog2(CODE_W);
  localparam logic [W-1:0] ONE   = W'(1);
  localparam logic [W-1:0] LM_C  = W'(LEAD_MARK_T);
  localparam logic [W-1:0] LS_C  = W'(LEAD_SPACE_T);
  localparam logic [W-1:0] BM_C  = W'(BIT_MARK_T);
  localparam logic [W-1:0] S0_C  = W'(ZERO_SPACE_T);
  localparam logic [W-1:0] S1_C  = W'(ONE_SPACE_T);
  localparam logic [W-1:0] RS_C  = W'(RPT_SPACE_T);
  localparam logic [W-1:0] PER_C = W'(RPT_PERIOD_T);
  localparam logic [BW-1:0] LAST_BIT = BW'(CODE_W - 1);

  seg_e              seg_q, seg_d;
  logic [W-1:0]      cnt_q, cnt_d;
  logic [W-1:0]      per_q, per_d;
  logic [CODE_W-1:0] shift_q, shift_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [RPT_W-1:0]  rpt_q, rpt_d;
  logic              done_q, done_d;
  logic              clr_d;

  always_comb begin
    seg_d   = seg_q;
    cnt_d   = cnt_q;
    per_d   = per_q;
    shift_d = shift_q;
    bit_d   = bit_q;
    rpt_d   = rpt_q;
    done_d  = 1'b0;
    clr_d   = 1'b0;
    if (seg_q == SEG_IDLE) begin
      if (start) begin
        seg_d   = SEG_LEAD_MARK;
        cnt_d   = LM_C;
        per_d   = PER_C;
        shift_d = code;
        bit_d   = '0;
        rpt_d   = rpt_num;
        clr_d   = 1'b1;
      end
    end else if (tick) begin
      per_d = per_q - ONE;
      if (cnt_q != ONE) begin
        cnt_d = cnt_q - ONE;
      end else begin
        case (seg_q)
          SEG_LEAD_MARK: begin
            seg_d = SEG_LEAD_SPACE;
            cnt_d = LS_C;
          end
          SEG_LEAD_SPACE: begin
            seg_d = SEG_BIT_MARK;
            cnt_d = BM_C;
          end
          SEG_BIT_MARK: begin
            seg_d = SEG_BIT_SPACE;
            cnt_d = shift_q[0] ? S1_C : S0_C;
          end
          SEG_BIT_SPACE: begin
            shift_d = shift_q >> 1;
            bit_d   = bit_q + BW'(1);
            cnt_d   = BM_C;
            seg_d   = (bit_q == LAST_BIT) ? SEG_STOP_MARK : SEG_BIT_MARK;
          end
          SEG_STOP_MARK: begin
            if (rpt_q == '0) begin
              seg_d  = SEG_IDLE;
              done_d = 1'b1;
            end else begin
              seg_d = SEG_GAP;
              cnt_d = per_q - ONE;
            end
          end
          SEG_GAP: begin
            seg_d = SEG_RPT_MARK;
            cnt_d = LM_C;
            per_d = PER_C;
          end
          SEG_RPT_MARK: begin
            seg_d = SEG_RPT_SPACE;
            cnt_d = RS_C;
          end
          SEG_RPT_SPACE: begin
            seg_d = SEG_RPT_STOP;
            cnt_d = BM_C;
          end
          SEG_RPT_STOP: begin
            rpt_d = rpt_q - RPT_W'(1);
            if (rpt_q == RPT_W'(1)) begin
              seg_d  = SEG_IDLE;
              done_d = 1'b1;
            end else begin
              seg_d = SEG_GAP;
              cnt_d = per_q - ONE;
            end
          end
          default: begin
            seg_d = SEG_IDLE;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q   <= SEG_IDLE;
      cnt_q   <= '0;
      per_q   <= '0;
      shift_q <= '0;
      bit_q   <= '0;
      rpt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      seg_q   <= seg_d;
      cnt_q   <= cnt_d;
      per_q   <= per_d;
      shift_q <= shift_d;
      bit_q   <= bit_d;
      rpt_q   <= rpt_d;
      done_q  <= done_d;
    end
  end

  assign tick_clr   = clr_d;
  assign busy       = (seg_q != SEG_IDLE);
  assign done       = done_q;
  assign carrier_en = is_burst(seg_q);

endmodule

// File: rtl/nec_ir_tx.sv
module nec_ir_tx #(
  parameter int CLK_PER_TICK = 50,
  parameter int LEAD_MARK_T  = 9000,
  parameter int LEAD_SPACE_T = 4500,
  parameter int BIT_MARK_T   = 560,
  parameter int ZERO_SPACE_T = 560,
  parameter int ONE_SPACE_T  = 1690,
  parameter int RPT_SPACE_T  = 2250,
  parameter int RPT_PERIOD_T = 108000,
  parameter int CAR_DIV      = 1316
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] code,
  input  logic [7:0]  rpt_num,
  output logic        busy,
  output logic        done,
  output logic        carrier_en,
  output logic        ir_out
);

  localparam int CAR_HIGH = CAR_DIV / 3;

  logic rst_i_n;
  logic tick;
  logic tick_clr;
  logic carrier;

  nec_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  nec_tick_gen #(
    .DIV (CLK_PER_TICK)
  ) u_tick (
    .clk   (clk),
    .rst_n (rst_i_n),
    .clr   (tick_clr),
    .tick  (tick)
  );

  nec_carrier_gen #(
    .PERIOD_CLK (CAR_DIV),
    .HIGH_CLK   (CAR_HIGH)
  ) u_car (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .carrier (carrier)
  );

  nec_frame_seq #(
    .LEAD_MARK_T  (LEAD_MARK_T),
    .LEAD_SPACE_T (LEAD_SPACE_T),
    .BIT_MARK_T   (BIT_MARK_T),
    .ZERO_SPACE_T (ZERO_SPACE_T),
    .ONE_SPACE_T  (ONE_SPACE_T),
    .RPT_SPACE_T  (RPT_SPACE_T),
    .RPT_PERIOD_T (RPT_PERIOD_T),
    .RPT_W        (8)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .start      (start),
    .code       (code),
    .rpt_num    (rpt_num),
    .tick       (tick),
    .tick_clr   (tick_clr),
    .busy       (busy),
    .done       (done),
    .carrier_en (carrier_en)
  );

  assign ir_out = carrier & carrier_en;

endmodule

// File: rtl/nec_ir_tx_chk.sv
module nec_ir_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic carrier_en,
  input logic ir_out
);

  // R9: output gated off whenever the carrier is disabled
  p_gate_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !carrier_en |-> !ir_out);

  // R10: no carrier outside a transfer
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !carrier_en);

  // R1: a transfer opens with a burst
  p_open_burst_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> carrier_en);

  // R8: busy only rises after a start request
  p_busy_from_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R11: done comes in the first idle cycle after busy
  p_done_at_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R11: done lasts a single cycle
  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind nec_ir_tx nec_ir_tx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .carrier_en (carrier_en),
  .ir_out     (ir_out)
);

// File: tb/nec_ir_tx_tb.sv
module nec_ir_tx_tb;

  localparam int K   = 2;
  localparam int LM  = 9;
  localparam int LS  = 5;
  localparam int BM  = 2;
  localparam int S0  = 2;
  localparam int S1  = 4;
  localparam int RS  = 3;
  localparam int PER = 250;
  localparam int CD  = 6;
  localparam int CH  = CD / 3;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [31:0] code;
  logic [7:0]  rpt_num;
  logic        busy, done, carrier_en, ir_out;

  int n_tests;
  int n_fail;
  int cycles;

  int    exp_lvl [0:255];
  int    exp_len [0:255];
  string exp_tag [0:255];
  int    n_exp;
  int    act_lvl [0:255];
  int    act_len [0:255];
  int    n_act;

  nec_ir_tx #(
    .CLK_PER_TICK (K),
    .LEAD_MARK_T  (LM),
    .LEAD_SPACE_T (LS),
    .BIT_MARK_T   (BM),
    .ZERO_SPACE_T (S0),
    .ONE_SPACE_T  (S1),
    .RPT_SPACE_T  (RS),
    .RPT_PERIOD_T (PER),
    .CAR_DIV      (CD)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .code       (code),
    .rpt_num    (rpt_num),
    .busy       (busy),
    .done       (done),
    .carrier_en (carrier_en),
    .ir_out     (ir_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int lvl, input int len, input string tag);
    exp_lvl[n_exp] = lvl;
    exp_len[n_exp] = len * K;
    exp_tag[n_exp] = tag;
    n_exp++;
  endtask

  // inject >= 0: cycle inside the transfer at which a competing start is driven
  task automatic run_xfer(input logic [31:0] c, input int r, input int inject);
    int tot;
    int cur, len, cyc, mism, car_err;
    int prev_ce, prev_ir, hi_len, hi_ok, last_rise;
    n_exp = 0;
    push(1, LM, "R1");
    push(0, LS, "R1");
    tot = LM + LS;
    for (int i = 0; i < 32; i++) begin
      push(1, BM, "R3");
      push(0, c[i] ? S1 : S0, "R2");
      tot += BM + (c[i] ? S1 : S0);
    end
    push(1, BM, "R4");
    tot += BM;
    for (int k = 0; k < r; k++) begin
      push(0, PER - tot, "R6");
      push(1, LM, "R5");
      push(0, RS, "R5");
      push(1, BM, "R5");
      tot = LM + RS + BM;
    end

    @(negedge clk);
    code = c; rpt_num = 8'(r); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R11 busy after start", int'(busy), 1);

    n_act = 0; cur = int'(carrier_en); len = 0; cyc = 0;
    prev_ce = 0; prev_ir = 0; hi_len = 0; hi_ok = 0; last_rise = -1; car_err = 0;
    while (busy && cyc < 20000) begin
      if (int'(carrier_en) != cur) begin
        if (n_act < 256) begin
          act_lvl[n_act] = cur; act_len[n_act] = len;
        end
        n_act++;
        cur = int'(carrier_en); len = 0;
      end
      len++;
      if (!carrier_en && ir_out) car_err++;
      if (carrier_en && prev_ce == 1) begin
        if (ir_out && prev_ir == 0) begin
          if (last_rise >= 0 && (cyc - last_rise) != CD) car_err++;
          last_rise = cyc; hi_len = 1; hi_ok = 1;
        end else if (ir_out) begin
          hi_len++;
        end else if (prev_ir == 1 && hi_ok == 1) begin
          if (hi_len != CH) car_err++;
          hi_ok = 0;
        end
      end else begin
        hi_ok = 0; last_rise = -1;
      end
      prev_ce = int'(carrier_en); prev_ir = int'(ir_out);
      if (cyc == inject) begin
        start = 1'b1; code = ~c; rpt_num = 8'(r + 2);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    if (n_act < 256) begin
      act_lvl[n_act] = cur; act_len[n_act] = len;
    end
    n_act++;
    check(done == 1'b1, "R11 done pulse at end", int'(done), 1);
    check(carrier_en == 1'b0, "R4 idle after last burst", int'(carrier_en), 0);
    check(n_act == n_exp, "R7 segment count", n_act, n_exp);
    mism = 0;
    for (int i = 0; i < n_exp && i < n_act && i < 256; i++) begin
      if (act_lvl[i] != exp_lvl[i] || act_len[i] != exp_len[i]) begin
        mism++;
        $display("FAIL %s segment %0d level/len actual=%0d/%0d expected=%0d/%0d",
                 exp_tag[i], i, act_lvl[i], act_len[i], exp_lvl[i], exp_len[i]);
      end
      n_tests++;
    end
    n_fail += mism;
    if (inject >= 0) check(mism == 0 && n_act == n_exp, "R8 start while busy ignored", mism, 0);
    check(car_err == 0, "R9 carrier gating/period/duty", car_err, 0);
    @(negedge clk);
    check(done == 1'b0, "R11 done single cycle", int'(done), 0);
  endtask

  initial begin
    n_tests = 0; n_fail = 0;
    rst_n = 1'b0; start = 1'b0; code = '0; rpt_num = '0;
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && carrier_en == 0 && ir_out == 0,
          "R10 reset state", int'({busy, done, carrier_en, ir_out}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy == 0 && carrier_en == 0 && ir_out == 0,
          "R10 idle after reset release", int'({busy, carrier_en, ir_out}), 0);

    // R2 walking one through every code position, no repeats
    for (int b = 0; b < 32; b++) run_xfer(32'h1 << b, 0, -1);
    run_xfer(32'h0000_0000, 0, -1);
    run_xfer(32'hFFFF_FFFF, 0, -1);
    // address/command with complements
    run_xfer({~8'h5A, 8'h5A, ~8'hEE, 8'hEE}, 1, -1);
    run_xfer({~8'h01, 8'h01, ~8'h80, 8'h80}, 3, -1);
    // R8 competing start in data frame and in repeat frame
    run_xfer(32'hC3A5_0F96, 2, 40);
    run_xfer(32'h1234_5678, 2, 700);
    run_xfer(32'h0, 5, -1);

    // R10 reset in the middle of a transfer
    @(negedge clk);
    code = 32'hDEAD_BEEF; rpt_num = 8'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (100) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(busy == 0 && carrier_en == 0 && ir_out == 0,
          "R10 mid-transfer reset", int'({busy, carrier_en, ir_out}), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy == 0 && done == 0, "R10 stays idle after reset", int'({busy, done}), 0);
    run_xfer(32'h00FF_00FF, 1, -1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    cycles = 0;
    while (cycles < 190000) begin
      @(posedge clk);
      cycles++;
    end
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=<190000 cycles", cycles);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule